// File: doc/BRIEF.md
# Accumulator Read Saturation Limiter

This block sits on the read side of a data ALU accumulator. It takes the accumulator's value, a code naming which part of it is being read, and a read strobe. From these it produces the word that goes out onto the data bus or into another ALU register. The accumulator has three fields. The top field holds the extension bits, the middle word is the most significant part, and the bottom word is the least significant part.

A read of the whole accumulator checks whether the extension bits carry more than sign information. This is true when the extension bits and the top bit of the middle word are not all equal. In that case the outgoing word is clamped to positive or negative full scale, and a sticky limit flag is latched. The accumulator itself is never written by this block. A read that names one of the three sub-fields directly bypasses the limiter.

The bus word is purely combinational from the inputs. The only state is the limit flag. The flag is set on a clock edge by a strobed whole-accumulator read that saturates. It is cleared by a dedicated clear input or by reset, and it keeps its value otherwise. The default widths are a 4-bit extension field and 16-bit words, which gives a 36-bit accumulator.

Top module: `acc_read_limiter`

## Requirements
- R1: With the source code `00` (whole accumulator), when the top EXT_W+1 bits (the extension field and the MSB of the middle word) are all equal, the bus word equals the middle word. For the defaults these are bits 35:31, and the middle word is bits 31:16.
- R2: With the source code `00`, when those guard bits differ and the accumulator MSB is 0, the bus word is positive full scale: 0 followed by all ones (0x7FFF at the defaults).
- R3: With the source code `00`, when those guard bits differ and the accumulator MSB is 1, the bus word is negative full scale: 1 followed by all zeros (0x8000 at the defaults).
- R4: With the source code `10`, the bus word is the middle word. With the code `11`, it is the bottom word. In both cases no limiting is applied, whatever the extension bits hold.
- R5: With the source code `01`, the bus word is the extension field sign-extended to the word width.
- R6: At a rising clock edge where the read strobe is high, the code is `00` and the guard bits differ, the limit flag becomes 1.
- R7: Once set, the limit flag stays 1 through later non-saturating reads and idle cycles, until it is cleared.
- R8: The limit flag is not set by a saturating value when the read strobe is low, nor by any sub-field read (codes `01`, `10`, `11`).
- R9: A high clear input clears the flag at the next rising edge. If a set condition occurs in the same cycle, the flag ends up 1.
- R10: An active-low reset clears the flag at once. The bus word follows its inputs in the same cycle with no strobe or clock needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| acc_in | input | EXT_W+2*WORD_W | Accumulator value being read |
| src_sel | input | 2 | Source code: 00 whole, 01 extension, 10 middle word, 11 bottom word |
| rd_en | input | 1 | Read strobe, qualifies flag setting |
| flag_clr | input | 1 | Clears the sticky limit flag |
| bus_out | output | WORD_W | Word placed on the bus |
| lim_flag | output | 1 | Sticky limit flag |

## Verification
The bench builds the block with EXT_W=2 and WORD_W=4. This makes a 10-bit accumulator, small enough to sweep all 1024 values under each of the four source codes. Every pattern of the guard bits is covered, including every positive and negative out-of-range value, so both full-scale codes are produced. Each strobed whole-accumulator read also has its flag outcome checked and is followed by a clear. Directed sequences then cover stickiness, an unstrobed read, a collision between set and clear, and reset while the flag is set.

// File: rtl/acc_lim_pkg.sv
package acc_lim_pkg;

  typedef enum logic [1:0] {
    SRC_WHOLE = 2'b00,
    SRC_EXT   = 2'b01,
    SRC_MID   = 2'b10,
    SRC_LOW   = 2'b11
  } src_sel_e;

endpackage

// File: rtl/acc_rst_sync.sv
module acc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] stage_q;
  logic [STAGES-1:0] stage_d;

  always_comb begin
    stage_d = {stage_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= '0;
    else        stage_q <= stage_d;
  end

  assign rst_sync_n = stage_q[STAGES-1];

endmodule

// File: rtl/acc_guard_detect.sv
module acc_guard_detect #(
  parameter int EXT_W = 4
) (
  input  logic [EXT_W:0] guard_bits,
  output logic           ext_used,
  output logic           neg_sign
);

  logic all_ones;
  logic all_zeros;

  always_comb begin
    all_ones  = &guard_bits;
    all_zeros = ~|guard_bits;
    ext_used  = !(all_ones || all_zeros);
    neg_sign  = guard_bits[EXT_W];
  end

endmodule

// File: rtl/acc_out_mux.sv
module acc_out_mux
  import acc_lim_pkg::*;
#(
  parameter int EXT_W  = 4,
  parameter int WORD_W = 16,
  localparam int ACC_W = EXT_W + 2 * WORD_W
) (
  input  logic [ACC_W-1:0]  acc,
  input  src_sel_e          sel,
  input  logic              ext_used,
  input  logic              neg_sign,
  output logic [WORD_W-1:0] word_out
);

  localparam logic [WORD_W-1:0] POS_FS = {1'b0, {(WORD_W-1){1'b1}}};
  localparam logic [WORD_W-1:0] NEG_FS = {1'b1, {(WORD_W-1){1'b0}}};

  logic [EXT_W-1:0]  ext_f;
  logic [WORD_W-1:0] mid_f;
  logic [WORD_W-1:0] low_f;
  logic [WORD_W-1:0] ext_wide;
  logic [WORD_W-1:0] whole_word;

  assign ext_f = acc[ACC_W-1 -: EXT_W];
  assign mid_f = acc[2*WORD_W-1 -: WORD_W];
  assign low_f = acc[WORD_W-1:0];

  generate
    if (EXT_W < WORD_W) begin : g_ext_sx
      assign ext_wide = {{(WORD_W-EXT_W){ext_f[EXT_W-1]}}, ext_f};
    end else begin : g_ext_trunc
      assign ext_wide = ext_f[WORD_W-1:0];
    end
  endgenerate

  always_comb begin
    if (ext_used) whole_word = neg_sign ? NEG_FS : POS_FS;
    else          whole_word = mid_f;
  end

  always_comb begin
    unique case (sel)
      SRC_WHOLE: word_out = whole_word;
      SRC_EXT:   word_out = ext_wide;
      SRC_MID:   word_out = mid_f;
      SRC_LOW:   word_out = low_f;
      default:   word_out = mid_f;
    endcase
  end

endmodule

// File: rtl/acc_lim_flag.sv
module acc_lim_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_req,
  input  logic clr_req,
  output logic flag
);

  logic flag_q;
  logic flag_d;
  logic flag_en;

  always_comb begin
    flag_en = set_req || clr_req;
    if (set_req) flag_d = 1'b1;
    else         flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_q <= 1'b0;
    else if (flag_en) flag_q <= flag_d;
  end

  assign flag = flag_q;

  assert_flag_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    set_req |=> flag);
  assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !clr_req) |=> flag);
  assert_flag_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_req && !set_req) |=> !flag);
  assert_flag_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag && !set_req) |=> !flag);

endmodule

// File: rtl/acc_read_limiter.sv
module acc_read_limiter
  import acc_lim_pkg::*;
#(
  parameter int EXT_W  = 4,
  parameter int WORD_W = 16,
  localparam int ACC_W = EXT_W + 2 * WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ACC_W-1:0]  acc_in,
  input  logic [1:0]        src_sel,
  input  logic              rd_en,
  input  logic              flag_clr,
  output logic [WORD_W-1:0] bus_out,
  output logic              lim_flag
);

  localparam int GUARD_W = EXT_W + 1;

  logic     rst_int_n;
  logic     ext_used;
  logic     neg_sign;
  logic     set_req;
  src_sel_e sel_e;

  assign sel_e = src_sel_e'(src_sel);

  acc_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  acc_guard_detect #(.EXT_W(EXT_W)) u_guard (
    .guard_bits (acc_in[ACC_W-1 -: GUARD_W]),
    .ext_used   (ext_used),
    .neg_sign   (neg_sign)
  );

  acc_out_mux #(.EXT_W(EXT_W), .WORD_W(WORD_W)) u_mux (
    .acc      (acc_in),
    .sel      (sel_e),
    .ext_used (ext_used),
    .neg_sign (neg_sign),
    .word_out (bus_out)
  );

  always_comb begin
    set_req = rd_en && (sel_e == SRC_WHOLE) && ext_used;
  end

  acc_lim_flag u_flag (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .set_req (set_req),
    .clr_req (flag_clr),
    .flag    (lim_flag)
  );

  assert_pass_mid_R1: assert property (@(posedge clk) disable iff (!rst_int_n)
    (sel_e == SRC_WHOLE && !ext_used) |-> bus_out == acc_in[2*WORD_W-1 -: WORD_W]);
  assert_pos_fs_R2: assert property (@(posedge clk) disable iff (!rst_int_n)
    (sel_e == SRC_WHOLE && ext_used && !acc_in[ACC_W-1])
      |-> (bus_out[WORD_W-1] == 1'b0 && &bus_out[WORD_W-2:0]));
  assert_neg_fs_R3: assert property (@(posedge clk) disable iff (!rst_int_n)
    (sel_e == SRC_WHOLE && ext_used && acc_in[ACC_W-1])
      |-> (bus_out[WORD_W-1] == 1'b1 && ~|bus_out[WORD_W-2:0]));
  assert_sub_bypass_R4: assert property (@(posedge clk) disable iff (!rst_int_n)
    (sel_e == SRC_LOW) |-> bus_out == acc_in[WORD_W-1:0]);
  assert_sub_no_set_R8: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!lim_flag && sel_e != SRC_WHOLE) |=> !lim_flag);

endmodule

// File: tb/acc_read_limiter_tb.sv
module acc_read_limiter_tb;

  localparam int EW = 2;
  localparam int WW = 4;
  localparam int AW = EW + 2 * WW;

  logic          clk;
  logic          rst_n;
  logic [AW-1:0] acc_in;
  logic [1:0]    src_sel;
  logic          rd_en;
  logic          flag_clr;
  logic [WW-1:0] bus_out;
  logic          lim_flag;

  int checks;
  int failures;
  bit done;

  acc_read_limiter #(.EXT_W(EW), .WORD_W(WW)) u_dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .acc_in   (acc_in),
    .src_sel  (src_sel),
    .rd_en    (rd_en),
    .flag_clr (flag_clr),
    .bus_out  (bus_out),
    .lim_flag (lim_flag)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit guard_used(input int a);
    int top;
    top = a >> (2 * WW - 1);
    return !(top == 0 || top == (1 << (EW + 1)) - 1);
  endfunction

  function automatic int exp_bus(input int a, input int sel);
    int mid, low, e;
    mid = (a >> WW) % (1 << WW);
    low = a % (1 << WW);
    e   = a >> (2 * WW);
    case (sel)
      0: begin
        if (!guard_used(a)) return mid;
        if ((a >> (AW - 1)) != 0) return 1 << (WW - 1);
        return (1 << (WW - 1)) - 1;
      end
      1: return (e >= (1 << (EW - 1))) ? e + (1 << WW) - (1 << EW) : e;
      2: return mid;
      default: return low;
    endcase
  endfunction

  function automatic string bus_tag(input int a, input int sel);
    if (sel == 1) return "R5";
    if (sel != 0) return "R4";
    if (!guard_used(a)) return "R1";
    return ((a >> (AW - 1)) != 0) ? "R3" : "R2";
  endfunction

  initial begin
    #(4 * 150000);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    checks = 0; failures = 0; done = 0;
    rst_n = 1'b0; acc_in = '0; src_sel = 2'b00; rd_en = 1'b0; flag_clr = 1'b0;
    repeat (3) @(negedge clk);
    chk("R10 reset flag", int'(lim_flag), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R10 flag after release", int'(lim_flag), 0);

    // exhaustive sweep: bus word (R1..R5), flag set (R6) or not (R8), clear (R9)
    for (int sel = 0; sel < 4; sel++) begin
      for (int v = 0; v < (1 << AW); v++) begin
        @(negedge clk);
        acc_in = v[AW-1:0]; src_sel = sel[1:0]; rd_en = 1'b1; flag_clr = 1'b0;
        #1;
        chk(bus_tag(v, sel), int'(bus_out), exp_bus(v, sel));
        @(negedge clk);
        rd_en = 1'b0;
        if (sel == 0 && guard_used(v)) begin
          chk("R6 flag set", int'(lim_flag), 1);
          flag_clr = 1'b1;
          @(negedge clk);
          flag_clr = 1'b0;
          chk("R9 flag cleared", int'(lim_flag), 0);
        end else begin
          chk("R8 flag not set", int'(lim_flag), 0);
        end
      end
    end

    // R8 / R10: saturating value with strobe low: bus limited at once, flag unchanged
    @(negedge clk);
    acc_in = 10'h100; src_sel = 2'b00; rd_en = 1'b0;
    #1;
    chk("R10 comb bus no strobe", int'(bus_out), 7);
    repeat (2) @(negedge clk);
    chk("R8 no strobe no set", int'(lim_flag), 0);

    // R7 sticky across non-saturating reads
    rd_en = 1'b1;
    @(negedge clk);
    acc_in = 10'h050; rd_en = 1'b1;
    repeat (3) @(negedge clk);
    rd_en = 1'b0;
    chk("R7 sticky after clean reads", int'(lim_flag), 1);
    repeat (2) @(negedge clk);
    chk("R7 sticky idle", int'(lim_flag), 1);

    // R9 set and clear together: set wins
    acc_in = 10'h2C0; rd_en = 1'b1; flag_clr = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    chk("R9 set wins over clear", int'(lim_flag), 1);
    @(negedge clk);
    flag_clr = 1'b0;
    chk("R9 clear alone", int'(lim_flag), 0);

    // R10 asynchronous reset while flag is set
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    chk("R6 set before reset", int'(lim_flag), 1);
    #1 rst_n = 1'b0;
    #1;
    chk("R10 async reset clears", int'(lim_flag), 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R10 flag stays clear", int'(lim_flag), 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule